// File: doc/BRIEF.md
# Audio Peak Limiter

This block guards one channel of a digital audio path against driving more power into the speaker than a chosen cap allows. Every clock it receives one signed sample and returns the same sample scaled by a gain factor. The factor sits at unity in normal operation and is cut back when the input gets too large.

The level that counts as too large is expressed at the input. It depends on two settings taken together: the amplifier gain that follows the block, and the power cap chosen for the channel. Both settings come in as 2-bit codes. They are sampled only on the first enabled cycle and then held until the block is disabled and enabled again.

When the input magnitude goes above the selected threshold, the factor is halved on that same sample. Once the input falls back, the factor climbs back toward unity one LSB at a time at a fixed, slow rate. While enable is low, the output is silent and the factor is restored to unity.

Top module: `audio_peak_limiter`

## Requirements
- R1: After reset, gainFactor equals unity (2^(GAIN_W-1), 2048 by default), sampleOut is 0 and limiterActive is 0.
- R2: The threshold is taken from a 16-entry table indexed by {gain code, limit code}. The limit code selects the power cap: 00 = 10 W, 01 = 12 W, 10 = 15 W, 11 = 20 W. The gain code selects the amplifier gain: 00 = 20 dB, 01 = 26 dB, 10 = 32 dB, 11 = 36 dB. The threshold voltages in mV, listed for caps 10/12/15/20 W, are: at 20 dB 1265/1386/1549/1789; at 26 dB 632/693/775/894; at 32 dB 316/346/387/447; at 36 dB 201/220/246/284. Each code is floor(mV*(2^(SAMPLE_W-1)-1)/FULL_SCALE_MV). A sample counts as over only when its magnitude is strictly greater than the code.
- R3: The gain and limit codes are captured on the first cycle in which enable is high after being low, and that cycle already uses them. Code changes while enable stays high have no effect.
- R4: Each enabled sample that is over threshold halves gainFactor (rounding down), with a floor of 1. The halved factor already scales that same sample.
- R5: While samples stay at or below threshold and gainFactor is below unity, gainFactor rises by exactly 1 on every RELEASE_DIV-th such sample (4 by default). Any over-threshold sample restarts this count.
- R6: limiterActive is 1 exactly when gainFactor is below unity.
- R7: One cycle after an enabled sample, sampleOut equals floor(sample*g / 2^(GAIN_W-1)), where g is the gainFactor updated by that sample.
- R8: A cycle with enable low makes sampleOut 0 and gainFactor unity after that clock edge, and clears the release count.
- R9: The most negative sample (-2^(SAMPLE_W-1)) is treated as magnitude 2^(SAMPLE_W-1) and is scaled without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel enable; its rising edge captures the codes |
| gainCode | input | 2 | Downstream amplifier gain selection |
| limitCode | input | 2 | Power cap selection |
| sampleIn | input | SAMPLE_W | Signed input sample |
| sampleOut | output | SAMPLE_W | Signed scaled sample, registered |
| gainFactor | output | GAIN_W | Current gain factor, unity = 2^(GAIN_W-1) |
| limiterActive | output | 1 | High while the gain is cut below unity |

## Verification
The hardest case to reach is the exact threshold edge for all sixteen gain/cap pairs. Each pair can only be selected through a disable/re-enable cycle. The stimulus therefore walks every pair in turn: it drops enable, applies the new codes, re-enables with a sample exactly at the code, and then sends one a single LSB above it. A second hard case is a release count cut short by a fresh peak, and a code change that lands while the channel is enabled. Random traffic with amplitudes clustered around the active threshold, mixed with short enable drops, covers both of these many times. A reference model in the bench scores every cycle.

// File: rtl/limiter_pkg.sv
package limiter_pkg;

  typedef struct packed {
    logic clear;
    logic attack;
    logic releaseStep;
  } strobes_t;

  typedef struct packed {
    logic [1:0] gain;
    logic [1:0] limit;
  } cfg_t;

  localparam int NUM_ENTRIES = 16;

  // threshold in millivolts for table index {gain, limit}
  function automatic int unsigned thr_mv(input int idx);
    int unsigned row;
    int unsigned col;
    row = (idx >> 2) & 3;
    col = idx & 3;
    case (row)
      0: case (col) 0: return 1265; 1: return 1386; 2: return 1549; default: return 1789; endcase
      1: case (col) 0: return 632;  1: return 693;  2: return 775;  default: return 894;  endcase
      2: case (col) 0: return 316;  1: return 346;  2: return 387;  default: return 447;  endcase
      default: case (col) 0: return 201; 1: return 220; 2: return 246; default: return 284; endcase
    endcase
  endfunction

  function automatic longint thr_code(input int idx, input int sampleW, input int fullScaleMv);
    longint scaled;
    longint maxCode;
    maxCode = (longint'(1) << sampleW) - 1;
    scaled = (longint'(thr_mv(idx)) * ((longint'(1) << (sampleW - 1)) - 1)) / longint'(fullScaleMv);
    if (scaled > maxCode) scaled = maxCode;
    return scaled;
  endfunction

endpackage

// File: rtl/limiter_thr_rom.sv
module limiter_thr_rom #(
  parameter int SAMPLE_W      = 16,
  parameter int FULL_SCALE_MV = 2000
) (
  input  logic [3:0]          idx,
  output logic [SAMPLE_W-1:0] threshold
);
  localparam int NUM = limiter_pkg::NUM_ENTRIES;

  logic [SAMPLE_W-1:0] entries [NUM];

  for (genvar i = 0; i < NUM; i++) begin : g_entry
    localparam longint CODE = limiter_pkg::thr_code(i, SAMPLE_W, FULL_SCALE_MV);
    assign entries[i] = CODE[SAMPLE_W-1:0];
  end

  assign threshold = entries[idx];
endmodule

// File: rtl/limiter_ctrl.sv
module limiter_ctrl
  import limiter_pkg::*;
#(
  parameter int SAMPLE_W      = 16,
  parameter int FULL_SCALE_MV = 2000,
  parameter int RELEASE_DIV   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [1:0]          gainCode,
  input  logic [1:0]          limitCode,
  input  logic [SAMPLE_W-1:0] magnitude,
  input  logic                atUnity,
  output strobes_t            strobes
);
  localparam int CNT_W = (RELEASE_DIV > 1) ? $clog2(RELEASE_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RELEASE_DIV - 1);

  logic             enableQ;
  cfg_t             cfgQ;
  cfg_t             cfgActive;
  logic             enableRise;
  logic [CNT_W-1:0] relCnt;
  logic [SAMPLE_W-1:0] threshold;
  logic             overThr;
  logic             countWrap;

  assign enableRise = enable & ~enableQ;
  assign cfgActive  = enableRise ? cfg_t'({gainCode, limitCode}) : cfgQ;

  limiter_thr_rom #(
    .SAMPLE_W     (SAMPLE_W),
    .FULL_SCALE_MV(FULL_SCALE_MV)
  ) thr_rom_i (
    .idx      (cfgActive),
    .threshold(threshold)
  );

  assign overThr   = enable && (magnitude > threshold);
  assign countWrap = (relCnt == CNT_LAST);

  always_comb begin
    strobes.clear       = ~enable;
    strobes.attack      = overThr;
    strobes.releaseStep = enable && !overThr && !atUnity && countWrap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      cfgQ    <= '0;
    end else begin
      enableQ <= enable;
      if (enableRise) cfgQ <= cfgActive;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relCnt <= '0;
    end else if (!enable || overThr || atUnity || countWrap) begin
      relCnt <= '0;
    end else begin
      relCnt <= relCnt + 1'b1;
    end
  end

  // R3: settings stay frozen while enable remains high
  p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && enableQ) |=> $stable(cfgQ));

  // R8: at most one strobe per cycle
  p_strobe_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.clear, strobes.attack, strobes.releaseStep}));

  if (RELEASE_DIV > 1) begin : g_spacing
    // R5: release steps never occur on consecutive samples
    p_release_spacing_r5: assert property (@(posedge clk) disable iff (!rstN)
      strobes.releaseStep |=> !strobes.releaseStep);
  end
endmodule

// File: rtl/limiter_datapath.sv
module limiter_datapath
  import limiter_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W   = 12
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobes_t                   strobes,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic [SAMPLE_W-1:0]        magnitude,
  output logic                       atUnity,
  output logic [GAIN_W-1:0]          gainFactor,
  output logic signed [SAMPLE_W-1:0] sampleOut
);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << (GAIN_W - 1);
  localparam logic [GAIN_W-1:0] FLOOR = GAIN_W'(1);
  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;

  logic [GAIN_W-1:0]          gainNext;
  logic [GAIN_W-1:0]          gainHalf;
  logic signed [GAIN_W:0]     gainSigned;
  logic signed [PROD_W-1:0]   product;
  logic signed [SAMPLE_W-1:0] scaled;

  assign magnitude = sampleIn[SAMPLE_W-1] ? (~sampleIn + 1'b1) : sampleIn;
  assign atUnity   = (gainFactor == UNITY);
  assign gainHalf  = gainFactor >> 1;

  always_comb begin
    if (strobes.clear) begin
      gainNext = UNITY;
    end else if (strobes.attack) begin
      gainNext = (gainHalf < FLOOR) ? FLOOR : gainHalf;
    end else if (strobes.releaseStep) begin
      gainNext = gainFactor + 1'b1;
    end else begin
      gainNext = gainFactor;
    end
  end

  assign gainSigned = {1'b0, gainNext};
  assign product    = sampleIn * gainSigned;
  assign scaled     = SAMPLE_W'(product >>> (GAIN_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainFactor <= UNITY;
      sampleOut  <= '0;
    end else begin
      gainFactor <= gainNext;
      sampleOut  <= strobes.clear ? '0 : scaled;
    end
  end

  // R8: a disabled cycle leaves silence and unity gain
  p_clear_unity_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (gainFactor == UNITY) && (sampleOut == '0));

  // R4: attack halves the factor when there is room to halve
  p_attack_halves_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.attack && gainFactor > FLOOR) |=> (gainFactor == ($past(gainFactor) >> 1)));

  // R5: a release step adds exactly one LSB
  p_release_lsb_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.releaseStep |=> (gainFactor == $past(gainFactor) + 1'b1));

  // R6: the factor never leaves [1, unity]
  p_gain_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (gainFactor >= FLOOR) && (gainFactor <= UNITY));
endmodule

// File: rtl/audio_peak_limiter.sv
module audio_peak_limiter
  import limiter_pkg::*;
#(
  parameter int SAMPLE_W      = 16,
  parameter int GAIN_W        = 12,
  parameter int RELEASE_DIV   = 4,
  parameter int FULL_SCALE_MV = 2000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       enable,
  input  logic [1:0]                 gainCode,
  input  logic [1:0]                 limitCode,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  output logic signed [SAMPLE_W-1:0] sampleOut,
  output logic [GAIN_W-1:0]          gainFactor,
  output logic                       limiterActive
);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << (GAIN_W - 1);

  strobes_t            strobes;
  logic [SAMPLE_W-1:0] magnitude;
  logic                atUnity;

  limiter_ctrl #(
    .SAMPLE_W     (SAMPLE_W),
    .FULL_SCALE_MV(FULL_SCALE_MV),
    .RELEASE_DIV  (RELEASE_DIV)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .gainCode (gainCode),
    .limitCode(limitCode),
    .magnitude(magnitude),
    .atUnity  (atUnity),
    .strobes  (strobes)
  );

  limiter_datapath #(
    .SAMPLE_W(SAMPLE_W),
    .GAIN_W  (GAIN_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sampleIn  (sampleIn),
    .magnitude (magnitude),
    .atUnity   (atUnity),
    .gainFactor(gainFactor),
    .sampleOut (sampleOut)
  );

  assign limiterActive = (gainFactor < UNITY);

  // R1: reset leaves the channel quiet at unity gain
  p_reset_state_r1: assert property (@(posedge clk)
    !rstN |=> (gainFactor == UNITY) && (sampleOut == '0));
endmodule

// File: tb/audio_peak_limiter_tb_top.sv
module audio_peak_limiter_tb_top;
  localparam int SW   = 16;
  localparam int GW   = 12;
  localparam int DIV  = 4;
  localparam int FSMV = 2000;
  localparam int U    = 1 << (GW - 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [1:0] gainCode = '0;
  logic [1:0] limitCode = '0;
  logic signed [SW-1:0] sampleIn = '0;
  logic signed [SW-1:0] sampleOut;
  logic [GW-1:0] gainFactor;
  logic limiterActive;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  int mGain = U;
  int mCnt = 0;
  longint mOut = 0;
  bit mEnPrev = 0;
  int mCfgG = 0;
  int mCfgL = 0;

  always #10 clk = ~clk;

  audio_peak_limiter #(
    .SAMPLE_W(SW), .GAIN_W(GW), .RELEASE_DIV(DIV), .FULL_SCALE_MV(FSMV)
  ) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .gainCode(gainCode),
    .limitCode(limitCode), .sampleIn(sampleIn), .sampleOut(sampleOut),
    .gainFactor(gainFactor), .limiterActive(limiterActive)
  );

  function automatic int mvOf(int g, int l);
    int cap20, cap15, cap12, cap10;
    case (g)
      0: begin cap20 = 1789; cap15 = 1549; cap12 = 1386; cap10 = 1265; end
      1: begin cap20 = 894;  cap15 = 775;  cap12 = 693;  cap10 = 632;  end
      2: begin cap20 = 447;  cap15 = 387;  cap12 = 346;  cap10 = 316;  end
      default: begin cap20 = 284; cap15 = 246; cap12 = 220; cap10 = 201; end
    endcase
    case (l)
      0: return cap10;
      1: return cap12;
      2: return cap15;
      default: return cap20;
    endcase
  endfunction

  function automatic int thrOf(int g, int l);
    return int'((longint'(mvOf(g, l)) * ((longint'(1) << (SW - 1)) - 1)) / FSMV);
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit en, int s, int gc, int lc);
    string tag;
    int t;
    int mag;
    enable    = en;
    sampleIn  = SW'(s);
    gainCode  = 2'(gc);
    limitCode = 2'(lc);
    @(posedge clk);
    tag = "R7";
    if (!en) begin
      mGain = U; mCnt = 0; mOut = 0; tag = "R8";
    end else begin
      if (!mEnPrev) begin mCfgG = gc; mCfgL = lc; end
      t = thrOf(mCfgG, mCfgL);
      mag = (s < 0) ? -s : s;
      if (mag > t) begin
        mGain = mGain / 2;
        if (mGain < 1) mGain = 1;
        mCnt = 0;
        tag = "R4";
      end else if (mGain < U) begin
        if (mCnt == DIV - 1) begin mGain++; mCnt = 0; tag = "R5"; end
        else mCnt++;
      end else begin
        mCnt = 0;
      end
      mOut = (longint'(s) * mGain) >>> (GW - 1);
    end
    mEnPrev = en;
    @(negedge clk);
    check(tag, "gainFactor", longint'(gainFactor), mGain);
    check("R7", "sampleOut", longint'(sampleOut), mOut);
    check("R6", "limiterActive", longint'(limiterActive), (mGain < U) ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "gainFactor", longint'(gainFactor), U);
    check("R1", "sampleOut", longint'(sampleOut), 0);
    check("R1", "limiterActive", longint'(limiterActive), 0);

    // R2: exact boundary for all 16 gain/cap pairs
    for (int g = 0; g < 4; g++) begin
      for (int l = 0; l < 4; l++) begin
        int t;
        t = thrOf(g, l);
        step(0, 0, g, l);
        step(1, t, g, l);
        check("R2", "at-threshold gain", longint'(gainFactor), U);
        step(1, -(t + 1), g, l);
        check("R2", "above-threshold gain", longint'(gainFactor), U / 2);
      end
    end

    // R3: codes changed while enabled are ignored (36 dB, 10 W stays active)
    step(0, 0, 3, 0);
    step(1, 0, 3, 0);
    step(1, 5000, 0, 3);
    check("R3", "frozen config still limits", longint'(gainFactor), U / 2);
    step(0, 0, 0, 3);
    step(1, 5000, 0, 3);
    check("R3", "new config after re-enable", longint'(gainFactor), U);

    // R5: release cadence and restart on a new peak
    step(1, 32000, 0, 3);
    for (int i = 0; i < DIV - 1; i++) step(1, 0, 0, 3);
    check("R5", "no step before count", longint'(gainFactor), U / 2);
    step(1, 0, 0, 3);
    check("R5", "one LSB after count", longint'(gainFactor), U / 2 + 1);
    step(1, 0, 0, 3);
    step(1, 0, 0, 3);
    step(1, 32000, 0, 3);
    for (int i = 0; i < DIV - 1; i++) step(1, 0, 0, 3);
    check("R5", "count restarted by peak", longint'(gainFactor), (U / 2 + 1) / 2);
    step(1, 0, 0, 3);
    check("R5", "step after restart", longint'(gainFactor), (U / 2 + 1) / 2 + 1);

    // R4: floor at one
    for (int i = 0; i < GW + 2; i++) step(1, 32000, 0, 3);
    check("R4", "gain floor", longint'(gainFactor), 1);

    // R8: disable restores unity and silence
    step(0, 1234, 0, 3);
    check("R8", "gain after disable", longint'(gainFactor), U);
    check("R8", "output after disable", longint'(sampleOut), 0);

    // R9: most negative sample
    step(1, -(1 << (SW - 1)), 0, 3);
    check("R9", "most negative scaled", longint'(sampleOut), -(1 << (SW - 2)));

    // random traffic clustered near the active threshold
    for (int n = 0; n < 4000; n++) begin
      bit en;
      int gc, lc, kind, amp, s, t;
      en = ($urandom % 40) != 0;
      gc = $urandom % 4;
      lc = $urandom % 4;
      t = thrOf(mEnPrev ? mCfgG : gc, mEnPrev ? mCfgL : lc);
      kind = $urandom % 8;
      if (kind < 4) amp = t - 100 + int'($urandom % 201);
      else if (kind < 7) amp = int'($urandom % (t + 1));
      else amp = 1 << (SW - 1);
      if (amp > (1 << (SW - 1))) amp = 1 << (SW - 1);
      if (amp < 0) amp = 0;
      s = ($urandom % 2) ? -amp : amp;
      if (s > (1 << (SW - 1)) - 1) s = (1 << (SW - 1)) - 1;
      step(en, s, gc, lc);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule